// File: doc/BRIEF.md
# Two-Channel Crypto Task Completion Interrupt

This block raises the completion interrupts of a crypto engine that runs two independent task channels: channel 0 belongs to the secure world and channel 1 to the non-secure world. Each channel keeps a software-visible interrupt enable, a sticky pending flag and a per-task request flag. The per-task request flag is taken from the top bit of a task descriptor's first word at the moment that word is accepted.

When the engine reports that a channel's task has finished, the channel's pending flag is set only if the channel enable and the per-task request flag are both 1. Software clears a pending flag by writing 1 to it. The secure channel's bits are shielded from non-secure bus accesses. Each channel drives its own interrupt line, which follows the pending flag one cycle later.

Top module: `twin_done_irq`

## Requirements
- R1: Channel 0 is the secure channel and drives `irq_sec`. Channel 1 is the non-secure channel and drives `irq_ns`. Activity on one channel never changes the other channel's state or line.
- R2: The enable register is at byte offset 0x0, with bit 0 for the secure channel and bit 1 for the non-secure channel. It resets to 0 and reads back the value written.
- R3: When `fetch_vld` is high, bit 31 of `fetch_word` is latched as the task request flag of channel `fetch_chan`. A later fetch changes only the flag of its own channel.
- R4: When `done_vld` is high, the pending flag of channel `done_chan` is set on that clock edge only if its enable bit and its latched task flag are both 1.
- R5: The status register is at byte offset 0x4, with bit 0 for the secure channel and bit 1 for the non-secure channel. It resets to 0, and a pending flag stays set until it is cleared.
- R6: Writing 1 to a status bit clears that flag. Writing 0 to it leaves it unchanged.
- R7: If a qualifying completion and a clear of the same channel occur in the same cycle, the flag remains set.
- R8: When `reg_secure` is low, bit 0 of both registers reads as 0 and writes to bit 0 are ignored. Bit 1 remains accessible.
- R9: Each interrupt line equals its channel's pending flag from the previous cycle, and is 0 after reset.
- R10: `reg_rdata` is combinational. It is 0 when `reg_rd` is low or when the offset is neither 0x0 nor 0x4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_vld | input | 1 | First descriptor word accepted |
| fetch_chan | input | 1 | Channel of the accepted descriptor (0 secure, 1 non-secure) |
| fetch_word | input | DW | First descriptor word |
| done_vld | input | 1 | Task completion pulse |
| done_chan | input | 1 | Channel whose task completed |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_secure | input | 1 | Access comes from the secure world |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data (combinational) |
| irq_sec | output | 1 | Secure channel interrupt |
| irq_ns | output | 1 | Non-secure channel interrupt |

## Verification
The assertions assume the following about the inputs:
- At most one fetch and at most one completion arrive per cycle, each naming a single channel through its select input.
- Every input is driven to a known value whenever the block leaves reset.

The bench drives all inputs on the falling clock edge, so they are stable at every rising edge. It holds the strobes low outside the cycle it is driving. It varies the secure attribute freely, so the assertions on shielded accesses see both worlds on every register offset.

// File: rtl/twin_done_irq_pkg.sv
package twin_done_irq_pkg;

    localparam int NCH = 2;

    typedef enum logic {
        CH_SEC = 1'b0,
        CH_NS  = 1'b1
    } chan_e;

    typedef struct packed {
        logic en;
        logic pend;
        logic task_req;
    } slot_state_t;

    // A channel is reachable when it is the non-secure one or the access is secure.
    function automatic logic chan_reachable(input int unsigned ch, input logic secure);
        return (ch == int'(CH_NS)) || secure;
    endfunction

endpackage

// File: rtl/twin_access_guard.sv
module twin_access_guard
    import twin_done_irq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DW     = 32,
    parameter int EN_OFS = 0,
    parameter int ST_OFS = 4
) (
    input  logic              reg_wr,
    input  logic              reg_secure,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [NCH-1:0]    reach,
    output logic [NCH-1:0]    en_we,
    output logic [NCH-1:0]    en_wv,
    output logic [NCH-1:0]    clr
);
    localparam logic [ADDR_W-1:0] EN_A = ADDR_W'(EN_OFS);
    localparam logic [ADDR_W-1:0] ST_A = ADDR_W'(ST_OFS);

    logic hit_en, hit_st;
    assign hit_en = reg_wr && (reg_addr == EN_A);
    assign hit_st = reg_wr && (reg_addr == ST_A);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign reach[c] = chan_reachable(c, reg_secure);
        assign en_we[c] = hit_en && reach[c];
        assign en_wv[c] = reg_wdata[c];
        assign clr[c]   = hit_st && reach[c] && reg_wdata[c];
    end

    // R8: a non-secure access never produces a strobe for the secure channel
    always_comb begin
        if (!reg_secure) begin
            a_r8_no_secure_strobe: assert (!en_we[CH_SEC] && !clr[CH_SEC]);
        end
    end

endmodule

// File: rtl/twin_task_slot.sv
module twin_task_slot
    import twin_done_irq_pkg::*;
#(
    parameter int DW          = 32,
    parameter int TASK_IE_BIT = 31
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        fetch,
    input  logic [DW-1:0] word,
    input  logic        done,
    input  logic        en_we,
    input  logic        en_wv,
    input  logic        clr,
    output slot_state_t st,
    output logic        irq
);
    slot_state_t st_q;
    logic        irq_q;
    logic        fire;

    assign fire = done && st_q.en && st_q.task_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '0;
            irq_q <= 1'b0;
        end else begin
            if (fetch) begin
                st_q.task_req <= word[TASK_IE_BIT];
            end
            if (en_we) begin
                st_q.en <= en_wv;
            end
            if (fire) begin
                st_q.pend <= 1'b1;
            end else if (clr) begin
                st_q.pend <= 1'b0;
            end
            irq_q <= st_q.pend;
        end
    end

    assign st  = st_q;
    assign irq = irq_q;

    // R3: the task flag follows the accepted word
    a_r3_task_latch: assert property (@(posedge clk) disable iff (rst)
        fetch |=> (st_q.task_req == $past(word[TASK_IE_BIT])));

    // R4: pending only rises after a completion with both enables set
    a_r4_rise_qualified: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.pend) |-> $past(done && st_q.en && st_q.task_req));

    // R5: pending is sticky without a clear
    a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
        (st_q.pend && !clr) |=> st_q.pend);

    // R7: a completion beats a simultaneous clear
    a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
        (done && st_q.en && st_q.task_req && clr) |=> st_q.pend);

    // R9: the line lags the pending flag by one cycle
    a_r9_line_lag: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_q == $past(st_q.pend)));

endmodule

// File: rtl/twin_done_irq.sv
module twin_done_irq
    import twin_done_irq_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DW          = 32,
    parameter int TASK_IE_BIT = 31,
    parameter int EN_OFS      = 0,
    parameter int ST_OFS      = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_vld,
    input  logic              fetch_chan,
    input  logic [DW-1:0]     fetch_word,
    input  logic              done_vld,
    input  logic              done_chan,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_secure,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              irq_sec,
    output logic              irq_ns
);
    localparam logic [ADDR_W-1:0] EN_A = ADDR_W'(EN_OFS);
    localparam logic [ADDR_W-1:0] ST_A = ADDR_W'(ST_OFS);

    logic [NCH-1:0] reach, en_we, en_wv, clr, irq_v;
    logic [NCH-1:0] en_vec, pend_vec;
    slot_state_t    st [NCH];

    twin_access_guard #(
        .ADDR_W(ADDR_W), .DW(DW), .EN_OFS(EN_OFS), .ST_OFS(ST_OFS)
    ) u_guard (
        .reg_wr    (reg_wr),
        .reg_secure(reg_secure),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reach     (reach),
        .en_we     (en_we),
        .en_wv     (en_wv),
        .clr       (clr)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_slot
        twin_task_slot #(.DW(DW), .TASK_IE_BIT(TASK_IE_BIT)) u_slot (
            .clk  (clk),
            .rst  (rst),
            .fetch(fetch_vld && (fetch_chan == 1'(c))),
            .word (fetch_word),
            .done (done_vld && (done_chan == 1'(c))),
            .en_we(en_we[c]),
            .en_wv(en_wv[c]),
            .clr  (clr[c]),
            .st   (st[c]),
            .irq  (irq_v[c])
        );
        assign en_vec[c]   = st[c].en   && reach[c];
        assign pend_vec[c] = st[c].pend && reach[c];
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            if (reg_addr == EN_A) begin
                reg_rdata[NCH-1:0] = en_vec;
            end else if (reg_addr == ST_A) begin
                reg_rdata[NCH-1:0] = pend_vec;
            end
        end
    end

    assign irq_sec = irq_v[CH_SEC];
    assign irq_ns  = irq_v[CH_NS];

    // R10: nothing is returned without a read strobe
    always_comb begin
        if (!reg_rd) begin
            a_r10_idle_read_zero: assert (reg_rdata == '0);
        end
    end

    // R1: a completion on the secure channel leaves the non-secure line alone
    a_r1_ns_isolated: assert property (@(posedge clk) disable iff (rst)
        (!g_slot[CH_NS].u_slot.st_q.pend && !(done_vld && done_chan == CH_NS))
        |=> !g_slot[CH_NS].u_slot.st_q.pend);

endmodule

// File: tb/twin_done_irq_tb.sv
`timescale 1ns/100ps
module twin_done_irq_tb;

    localparam int ADDR_W = 4;
    localparam int DW     = 32;

    logic clk = 1'b0;
    logic rst;
    logic fetch_vld, fetch_chan, done_vld, done_chan;
    logic [DW-1:0] fetch_word;
    logic reg_wr, reg_rd, reg_secure;
    logic [ADDR_W-1:0] reg_addr;
    logic [DW-1:0] reg_wdata, reg_rdata;
    logic irq_sec, irq_ns;

    int checks = 0;
    int errors = 0;

    logic [1:0] m_en, m_st, m_tie, m_irq;

    always #2.5 clk = ~clk;

    twin_done_irq u_dut (
        .clk(clk), .rst(rst),
        .fetch_vld(fetch_vld), .fetch_chan(fetch_chan), .fetch_word(fetch_word),
        .done_vld(done_vld), .done_chan(done_chan),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_secure(reg_secure),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_sec(irq_sec), .irq_ns(irq_ns)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] read_model(input logic [3:0] a, input logic sec);
        logic [1:0] mask;
        mask = sec ? 2'b11 : 2'b10;
        if (a == 4'h0) return {30'b0, m_en & mask};
        if (a == 4'h4) return {30'b0, m_st & mask};
        return 32'b0;
    endfunction

    task automatic peek(input string req, input logic [3:0] a, input logic sec);
        reg_rd = 1'b1; reg_addr = a; reg_secure = sec;
        #0.3;
        chk(req, reg_rdata, read_model(a, sec));
        reg_rd = 1'b0;
    endtask

    task automatic idle_inputs();
        fetch_vld = 0; fetch_chan = 0; fetch_word = '0;
        done_vld = 0; done_chan = 0;
        reg_wr = 0; reg_rd = 0; reg_secure = 0; reg_addr = '0; reg_wdata = '0;
    endtask

    task automatic cyc(input string tag,
                       input logic fv, input logic fc, input logic [31:0] fw,
                       input logic dv, input logic dc,
                       input logic wr, input logic [3:0] a, input logic [31:0] wd,
                       input logic sec);
        logic [1:0] nst, nen, ntie;
        @(negedge clk);
        fetch_vld = fv; fetch_chan = fc; fetch_word = fw;
        done_vld = dv; done_chan = dc;
        reg_wr = wr; reg_addr = a; reg_wdata = wd; reg_secure = sec;
        @(posedge clk);
        nst = m_st; nen = m_en; ntie = m_tie;
        for (int c = 0; c < 2; c++) begin
            logic allow, setc, clrc;
            allow = (c == 1) || sec;
            setc  = dv && (dc == 1'(c)) && m_en[c] && m_tie[c];
            clrc  = wr && (a == 4'h4) && allow && wd[c];
            if (setc) nst[c] = 1'b1;
            else if (clrc) nst[c] = 1'b0;
            if (wr && (a == 4'h0) && allow) nen[c] = wd[c];
            if (fv && (fc == 1'(c))) ntie[c] = fw[31];
        end
        m_irq = m_st; m_st = nst; m_en = nen; m_tie = ntie;
        #0.5;
        idle_inputs();
        #0.2;
        chk({tag, " R9/R1 irq"}, {30'b0, irq_ns, irq_sec}, {30'b0, m_irq});
        peek({tag, " R2 enable"}, 4'h0, 1'b1);
        peek({tag, " R5 status"}, 4'h4, 1'b1);
        peek({tag, " R8 ns view"}, 4'h4, 1'b0);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        m_en = 0; m_st = 0; m_tie = 0; m_irq = 0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R9 reset irq", {30'b0, irq_ns, irq_sec}, 32'h0);
        peek("R2 reset enable", 4'h0, 1'b1);
        peek("R5 reset status", 4'h4, 1'b1);

        cyc("R2", 0,0,0, 0,0, 1,4'h0,32'h3, 1);
        cyc("R3", 1,0,32'h8000_0000, 0,0, 0,0,0, 0);
        cyc("R3", 1,1,32'h7fff_ffff, 0,0, 0,0,0, 0);
        cyc("R4", 0,0,0, 1,1, 0,0,0, 0);             // ns task flag 0: no set
        cyc("R4", 0,0,0, 1,0, 0,0,0, 0);             // secure sets
        cyc("R9", 0,0,0, 0,0, 0,0,0, 0);
        cyc("R6", 0,0,0, 0,0, 1,4'h4,32'h0, 1);      // write 0: no effect
        cyc("R8", 0,0,0, 0,0, 1,4'h4,32'h1, 0);      // ns clear of secure ignored
        cyc("R8", 0,0,0, 0,0, 1,4'h0,32'h2, 0);      // ns cannot drop secure enable
        cyc("R6", 0,0,0, 0,0, 1,4'h4,32'h1, 1);      // secure clear
        cyc("R7", 0,0,0, 1,0, 1,4'h4,32'h1, 1);      // set wins over clear
        cyc("R3", 1,0,32'h0, 0,0, 0,0,0, 0);         // flag now 0
        cyc("R4", 0,0,0, 1,0, 1,4'h4,32'h1, 1);      // clear, completion unqualified
        cyc("R4", 1,1,32'h8000_0000, 0,0, 1,4'h0,32'h0, 1);
        cyc("R4", 0,0,0, 1,1, 0,0,0, 0);             // enable off: no set
        peek("R10 unmapped", 4'h8, 1'b1);
        chk("R10 idle read", reg_rdata, 32'h0);

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom();
            cyc("RND R4", r[0], r[1], {r[2], 27'h0, r[7:4]}, r[8], r[9],
                r[10] && r[11], r[12] ? 4'h4 : (r[13] ? 4'h0 : 4'h8),
                {30'b0, r[15:14]}, r[16]);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd12345));
    end

endmodule